// File: doc/BRIEF.md
# LCD Pixel Data Serializer

This block turns frame-buffer bytes for one display line into the words placed on the panel data pins, one word for each shift-clock tick. Bytes arrive over valid/ready streams and hold one pixel per bit. The most significant bit of each byte is the pixel that appears earliest on the line. The block has two 4-bit output buses, an upper one and a lower one. Three modes share them. In narrow single-panel mode only the upper bus carries pixels. In wide single-panel mode both buses carry one line. In split-panel mode the upper bus drives the top half of the panel and the lower bus drives the bottom half.

A line timing generator controls the block. It pulses `line_start` together with the mode and the number of shift clocks in the line. It then pulses `shift_tick` once for each shift clock. The block pulls bytes only on ticks that need new data. It pulses `line_done` when the last word goes out, and it holds its outputs at zero until the next line. Frame-buffer addressing, gray-shade modulation and the generation of the shift clock itself are not part of this block.

Top module: `lcd_pix_shifter`

## Requirements
- R1: While reset is held, and on leaving reset, `pd_up`, `pd_lo`, `line_done`, `underrun`, `up_ready` and `lo_ready` are all 0.
- R2: In mode 0 (narrow single panel), and in mode 3, which behaves the same, each upper byte serves two ticks. Bits 7:4 go to `pd_up` first, then bits 3:0. `pd_lo` stays 0, and `pd_up[3]` carries the earliest of the four pixels.
- R3: In mode 1 (wide single panel), each tick takes one upper byte and drives bits 7:4 on `pd_up` and bits 3:0 on `pd_lo`.
- R4: In mode 2 (split panel), each pair of ticks takes one upper byte and one lower byte together. The first tick drives the high nibbles on `pd_up` and `pd_lo`, and the second tick drives the low nibbles.
- R5: `line_done` is high for exactly one cycle. That cycle is the one in which the word for the `line_clocks`-th tick since `line_start` appears.
- R6: On a tick after the line has completed, and on any tick while idle, the outputs are 0, no byte is accepted, and `up_ready`/`lo_ready` stay low whenever `shift_tick` is low.
- R7: The mode is captured only on `line_start`. A change on `mode_sel` in the middle of a line has no effect on that line.
- R8: If a tick needs a byte that is not valid, that word is all zeros and `underrun` rises. The tick still counts toward the line length, and `underrun` stays high until the next `line_start`.
- R9: In mode 2, a byte is accepted on one stream only when the other stream also presents one. When only one stream is valid, neither stream is consumed.
- R10: `line_start` restarts the line even in the middle of one. On the next cycle the outputs, `line_done` and `underrun` are 0. The count is reloaded and any half-used byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Begin a line; captures mode and length |
| mode_sel | input | 2 | 0/3 narrow single, 1 wide single, 2 split panel |
| line_clocks | input | CNT_W | Shift clocks in the line |
| shift_tick | input | 1 | One pulse per shift clock |
| up_data | input | 8 | Upper stream byte, MSB earliest pixel |
| up_valid | input | 1 | Upper stream valid |
| up_ready | output | 1 | Upper stream ready |
| lo_data | input | 8 | Lower-half stream byte (split mode) |
| lo_valid | input | 1 | Lower stream valid |
| lo_ready | output | 1 | Lower stream ready |
| pd_up | output | 4 | Upper panel data nibble |
| pd_lo | output | 4 | Lower panel data nibble |
| line_done | output | 1 | Last word of the line is on the pins |
| underrun | output | 1 | A needed byte was missing in this line |

## Verification
Every output word is registered at the clock edge that samples `shift_tick`, so each tick's result is due one edge later. `line_done` appears in that same cycle as the final word. Clearing after `line_start` also takes exactly one edge. The bench raises the tick on a falling edge and records an expected word for it. The monitor compares that word at the next falling edge, after the edge that sampled the tick. Streams are popped at the rising edge on which valid and ready are both high. The checks then look at the queue depth to confirm which bytes were left unconsumed.

// File: rtl/lcd_pix_shifter.sv
module lcd_pix_shifter #(
  parameter int MAX_CLOCKS = 1024,
  localparam int CNT_W = $clog2(MAX_CLOCKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic [1:0]       mode_sel,
  input  logic [CNT_W-1:0] line_clocks,
  input  logic             shift_tick,
  input  logic [7:0]       up_data,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [7:0]       lo_data,
  input  logic             lo_valid,
  output logic             lo_ready,
  output logic [3:0]       pd_up,
  output logic [3:0]       pd_lo,
  output logic             line_done,
  output logic             underrun
);

  localparam logic [1:0] MODE_WIDE  = 2'd1;
  localparam logic [1:0] MODE_SPLIT = 2'd2;

  logic             active;
  logic [CNT_W-1:0] left;
  logic [1:0]       mode_q;
  logic             phase;
  logic [3:0]       hold_up, hold_lo;

  wire wide  = (mode_q == MODE_WIDE);
  wire split = (mode_q == MODE_SPLIT);
  wire fetch = active && shift_tick && (left != '0) && !phase;
  wire have  = split ? (up_valid && lo_valid) : up_valid;

  assign up_ready = fetch && (!split || lo_valid);
  assign lo_ready = fetch && split && up_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      left      <= '0;
      mode_q    <= '0;
      phase     <= 1'b0;
      hold_up   <= '0;
      hold_lo   <= '0;
      pd_up     <= '0;
      pd_lo     <= '0;
      line_done <= 1'b0;
      underrun  <= 1'b0;
    end else if (line_start) begin
      active    <= 1'b1;
      left      <= line_clocks;
      mode_q    <= mode_sel;
      phase     <= 1'b0;
      hold_up   <= '0;
      hold_lo   <= '0;
      pd_up     <= '0;
      pd_lo     <= '0;
      line_done <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      line_done <= 1'b0;
      if (active && shift_tick) begin
        if (left == '0) begin
          active <= 1'b0;
          pd_up  <= '0;
          pd_lo  <= '0;
        end else begin
          left      <= left - 1'b1;
          line_done <= (left == CNT_W'(1));
          if (phase) begin
            pd_up <= hold_up;
            pd_lo <= split ? hold_lo : 4'd0;
            phase <= 1'b0;
          end else if (!have) begin
            pd_up    <= '0;
            pd_lo    <= '0;
            underrun <= 1'b1;
          end else if (wide) begin
            pd_up <= up_data[7:4];
            pd_lo <= up_data[3:0];
          end else begin
            pd_up   <= up_data[7:4];
            pd_lo   <= split ? lo_data[7:4] : 4'd0;
            hold_up <= up_data[3:0];
            hold_lo <= lo_data[3:0];
            phase   <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/lcd_pix_shifter_chk.sv
module lcd_pix_shifter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic       shift_tick,
  input logic       up_valid,
  input logic       up_ready,
  input logic       lo_valid,
  input logic       lo_ready,
  input logic [3:0] pd_up,
  input logic [3:0] pd_lo,
  input logic       line_done,
  input logic       underrun,
  input logic [1:0] mode_q
);

  // R6
  ready_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ready || lo_ready) |-> shift_tick);

  // R9
  split_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> ((up_valid && up_ready) == (lo_valid && lo_ready)));

  // R5
  done_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> $past(shift_tick));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  // R10
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(line_start) |-> (pd_up == 4'd0 && pd_lo == 4'd0 && !underrun && !line_done));

  // R2
  narrow_lo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 || mode_q == 2'd3) |-> (pd_lo == 4'd0 && !lo_ready));

  // R8
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> $past(shift_tick));

endmodule

bind lcd_pix_shifter lcd_pix_shifter_chk u_lcd_pix_shifter_chk (.*);

// File: tb/test_lcd_pix_shifter.sv
module test_lcd_pix_shifter;
  localparam int CW = $clog2(1024 + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0, line_start = 1'b0, shift_tick = 1'b0;
  logic [1:0]    mode_sel = 2'd0;
  logic [CW-1:0] line_clocks = '0;
  logic [7:0]    up_data = '0, lo_data = '0;
  logic          up_valid = 1'b0, lo_valid = 1'b0;
  logic          up_ready, lo_ready, line_done, underrun;
  logic [3:0]    pd_up, pd_lo;

  lcd_pix_shifter i_lcd_pix_shifter (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] up_q[$], lo_q[$];
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;

  always @(negedge clk) begin
    up_valid = up_q.size() > 0;
    up_data  = up_valid ? up_q[0] : 8'h00;
    lo_valid = lo_q.size() > 0;
    lo_data  = lo_valid ? lo_q[0] : 8'h00;
  end

  always @(posedge clk) begin
    if (up_valid && up_ready) void'(up_q.pop_front());
    if (lo_valid && lo_ready) void'(lo_q.pop_front());
    pend <= shift_tick;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check("R6 stray tick", 1, 0);
      else check(tag_q.pop_front(), {22'd0, pd_up, pd_lo, line_done, underrun}, {22'd0, exp_q.pop_front()});
    end
  end

  task automatic shift(logic [3:0] u, logic [3:0] l, logic d, logic ur, string tag);
    exp_q.push_back({u, l, d, ur});
    tag_q.push_back(tag);
    shift_tick = 1'b1;
    @(negedge clk);
    shift_tick = 1'b0;
  endtask

  task automatic start(logic [1:0] m, int n);
    mode_sel    = m;
    line_clocks = CW'(n);
    line_start  = 1'b1;
    @(negedge clk);
    line_start  = 1'b0;
    check("R10 start clears", {pd_up, pd_lo, line_done, underrun}, 0);
  endtask

  task automatic load_up(logic [7:0] b);
    @(posedge clk); up_q.push_back(b); @(negedge clk);
  endtask

  task automatic load_lo(logic [7:0] b);
    @(posedge clk); lo_q.push_back(b); @(negedge clk);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", {pd_up, pd_lo, line_done, underrun, up_ready, lo_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {pd_up, pd_lo, line_done, underrun, up_ready, lo_ready}, 0);

    load_up(8'hA5); load_up(8'h3C); load_up(8'hF0);
    start(2'd0, 6);
    shift(4'hA, 4'h0, 0, 0, "R2"); shift(4'h5, 4'h0, 0, 0, "R2");
    shift(4'h3, 4'h0, 0, 0, "R2"); shift(4'hC, 4'h0, 0, 0, "R2");
    shift(4'hF, 4'h0, 0, 0, "R2"); shift(4'h0, 4'h0, 1, 0, "R5");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");
    load_up(8'h42);
    shift(4'h0, 4'h0, 0, 0, "R6 idle");
    check("R6 idle no pop", up_q.size(), 1);
    start(2'd1, 1);
    shift(4'h4, 4'h2, 1, 0, "R3");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    load_up(8'h5A); load_up(8'hC3); load_up(8'h81);
    start(2'd1, 3);
    shift(4'h5, 4'hA, 0, 0, "R3"); shift(4'hC, 4'h3, 0, 0, "R3");
    shift(4'h8, 4'h1, 1, 0, "R3");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    load_up(8'h12); load_up(8'h34); load_lo(8'hAB); load_lo(8'hCD);
    start(2'd2, 4);
    shift(4'h1, 4'hA, 0, 0, "R4"); shift(4'h2, 4'hB, 0, 0, "R4");
    shift(4'h3, 4'hC, 0, 0, "R4"); shift(4'h4, 4'hD, 1, 0, "R4");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    load_up(8'h66); load_up(8'h99);
    start(2'd1, 2);
    shift(4'h6, 4'h6, 0, 0, "R7");
    mode_sel = 2'd0;
    shift(4'h9, 4'h9, 1, 0, "R7");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    load_up(8'hB7);
    start(2'd3, 2);
    shift(4'hB, 4'h0, 0, 0, "R2 mode3"); shift(4'h7, 4'h0, 1, 0, "R2 mode3");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    start(2'd1, 2);
    shift(4'h0, 4'h0, 0, 1, "R8 missing");
    load_up(8'h96);
    shift(4'h9, 4'h6, 1, 1, "R8 sticky");
    shift(4'h0, 4'h0, 0, 1, "R8 drain");
    load_up(8'hE1);
    start(2'd1, 1);
    shift(4'hE, 4'h1, 1, 0, "R10");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    load_up(8'h7E);
    start(2'd2, 3);
    shift(4'h0, 4'h0, 0, 1, "R9 one side");
    check("R9 upper kept", up_q.size(), 1);
    load_lo(8'h1D);
    shift(4'h7, 4'h1, 0, 1, "R9"); shift(4'hE, 4'hD, 1, 1, "R9");
    shift(4'h0, 4'h0, 0, 1, "R9 drain");

    load_up(8'h58); load_up(8'h2F);
    start(2'd0, 4);
    shift(4'h5, 4'h0, 0, 0, "R10 pre");
    start(2'd1, 1);
    shift(4'h2, 4'hF, 1, 0, "R10 restart");
    shift(4'h0, 4'h0, 0, 0, "R6 drain");

    repeat (2) @(negedge clk);
    check("R6 queues drained", {up_q.size(), lo_q.size(), exp_q.size()}, 0);
    report();
  end
endmodule